// File: doc/BRIEF.md
# Debug Register APB Slave with Halt Handshake

This block is an APB3 slave that opens a 4 KB window of word-sized debug registers to a debugger or to system software. Only word address bits [11:2] reach the block. A separate source input marks each access as coming from the external debugger (high) or from software (low). The window holds three live registers: a read-only ROM locator built from tie-off inputs, a debug status/control word, and a power-down control word. All other offsets read as zero and accept writes with no effect.

Next to the bus, the block takes part in the external halt handshake. An external halt request is held high until the acknowledge output rises. The acknowledge output follows the core's "halted" indication. The debugger can also force it high through a status bit. When the core enters the halted state while the request is high, the status word records the entry cause. Bit 0 of the power-down control word drives a keep-powered output to the power controller.

Top module: `dbg_apb_regs`

## Requirements
- R1: Every access completes in its first access-phase cycle (PREADY high, no wait state), except the case in R5. PSLVERR stays low except in R5.
- R2: Word offsets other than 0x000, 0x088 and 0x310 read as zero without error. Writes to them change no readable register and no output.
- R3: The ROM locator at offset 0x000 reads the 20-bit base input in bits [31:12] and 2'b11 in bits [1:0] when the valid input is high, or 2'b00 when it is low. All other bits read zero. Writes are ignored.
- R4: The status word at offset 0x088 holds the entry-cause field in bits [5:2] and the force-acknowledge bit in bit 10. All other bits read zero. A debugger-sourced write loads both fields from the write data.
- R5: A software-sourced write (source input low) to offset 0x088 takes exactly one wait state, then completes with PSLVERR high and leaves the status word unchanged. Software reads of it complete normally.
- R6: In the cycle after the halted input rises while the halt request is high, bits [5:2] of the status word become 4'b0100. A rise of the halted input with the request low leaves the field unchanged.
- R7: The acknowledge output is high exactly when the halted input is high or status bit 10 is set.
- R8: Bit 0 of the power-down word at offset 0x310 is writable from either source and drives the keep-powered output from the cycle after the write. Its other bits read zero.
- R9: Reset clears the status word and the power-down word, and drives the acknowledge and keep-powered outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write when high |
| paddr_i | input | 10 | APB word address, byte address bits [11:2] |
| paddr_src_i | input | 1 | Access source: 1 debugger, 0 software |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data, zero outside read access phases |
| pready_o | output | 1 | APB ready |
| pslverr_o | output | 1 | APB slave error |
| halt_req_i | input | 1 | External halt request, held until acknowledged |
| core_halted_i | input | 1 | Core reports it is in the halted state |
| rom_base_i | input | 20 | Debug ROM base address bits [31:12], tie-off |
| rom_valid_i | input | 1 | ROM base valid, tie-off |
| dbg_ack_o | output | 1 | Halt acknowledge |
| no_pwrdn_o | output | 1 | Keep-powered request to the power controller |

## Verification
If the entry-cause field or the force-acknowledge bit is corrupted, the error shows on the acknowledge output at once through R7, or on the next read of offset 0x088. If the wait-state flag sticks, the next software write to the status word shows a wrong wait count or a missing error in that same transfer. A stale power-down bit shows on the keep-powered output one cycle after the write that should have changed it. Read data is compared for every read, and the wait-state count and the error flag for every transfer. A fault therefore appears at the end of the first transfer that touches the bad state.

// File: rtl/dbg_apb_pkg.sv
package dbg_apb_pkg;
  localparam int unsigned AW = 10;
  localparam int unsigned DW = 32;

  // word offsets (byte offset >> 2)
  localparam logic [AW-1:0] OFS_ROM  = 10'h000;
  localparam logic [AW-1:0] OFS_STAT = 10'h022;
  localparam logic [AW-1:0] OFS_PWR  = 10'h0C4;

  localparam int unsigned STAT_CODE_LSB = 2;
  localparam int unsigned STAT_CODE_W   = 4;
  localparam int unsigned STAT_FACK_BIT = 10;
  localparam logic [STAT_CODE_W-1:0] ENTRY_EXT_HALT = 4'b0100;

  typedef enum logic [1:0] {SEL_NONE, SEL_ROM, SEL_STAT, SEL_PWR} reg_sel_e;
endpackage

// File: rtl/dbg_apb_access.sv
module dbg_apb_access
  import dbg_apb_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          psel_i,
  input  logic          penable_i,
  input  logic          pwrite_i,
  input  logic [AW-1:0] paddr_i,
  input  logic          src_dbg_i,
  output logic          pready_o,
  output logic          pslverr_o,
  output logic          wr_en_o,
  output logic          rd_en_o,
  output reg_sel_e      sel_o
);
  logic access, guarded, stall, wait_q;

  always_comb begin
    unique case (paddr_i)
      OFS_ROM:  sel_o = SEL_ROM;
      OFS_STAT: sel_o = SEL_STAT;
      OFS_PWR:  sel_o = SEL_PWR;
      default:  sel_o = SEL_NONE;
    endcase
  end

  assign access    = psel_i & penable_i;
  // software write to the status word: one wait state, then error
  assign guarded   = access & pwrite_i & ~src_dbg_i & (sel_o == SEL_STAT);
  assign stall     = guarded & ~wait_q;
  assign pready_o  = access & ~stall;
  assign pslverr_o = guarded & wait_q;
  assign wr_en_o   = pready_o & pwrite_i & ~guarded;
  assign rd_en_o   = access & ~pwrite_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wait_q <= 1'b0;
    else if (stall)    wait_q <= 1'b1;
    else if (pready_o) wait_q <= 1'b0;
  end
endmodule

// File: rtl/dbg_status_ctrl.sv
module dbg_status_ctrl
  import dbg_apb_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          halt_req_i,
  input  logic          core_halted_i,
  output logic [DW-1:0] stat_o,
  output logic          dbg_ack_o
);
  logic [STAT_CODE_W-1:0] code_q;
  logic                   fack_q, halted_q, entry;
  logic                   unused_wdata;

  assign unused_wdata = ^{wdata_i[DW-1:STAT_FACK_BIT+1],
                          wdata_i[STAT_FACK_BIT-1:STAT_CODE_LSB+STAT_CODE_W],
                          wdata_i[STAT_CODE_LSB-1:0]};

  assign entry = core_halted_i & ~halted_q & halt_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halted_q <= 1'b0;
      code_q   <= '0;
      fack_q   <= 1'b0;
    end else begin
      halted_q <= core_halted_i;
      if (entry)        code_q <= ENTRY_EXT_HALT;
      else if (wr_en_i) code_q <= wdata_i[STAT_CODE_LSB +: STAT_CODE_W];
      if (wr_en_i)      fack_q <= wdata_i[STAT_FACK_BIT];
    end
  end

  always_comb begin
    stat_o = '0;
    stat_o[STAT_CODE_LSB +: STAT_CODE_W] = code_q;
    stat_o[STAT_FACK_BIT] = fack_q;
  end

  assign dbg_ack_o = core_halted_i | fack_q;
endmodule

// File: rtl/dbg_rom_view.sv
module dbg_rom_view #(
  parameter int unsigned ROM_W = 20,
  parameter int unsigned DW    = 32
) (
  input  logic [ROM_W-1:0] base_i,
  input  logic             valid_i,
  output logic [DW-1:0]    word_o
);
  always_comb begin
    word_o = '0;
    word_o[DW-1 -: ROM_W] = base_i;
    word_o[1:0] = {2{valid_i}};
  end
endmodule

// File: rtl/dbg_apb_regs.sv
module dbg_apb_regs
  import dbg_apb_pkg::*;
#(
  parameter int unsigned ROM_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             psel_i,
  input  logic             penable_i,
  input  logic             pwrite_i,
  input  logic [AW-1:0]    paddr_i,
  input  logic             paddr_src_i,
  input  logic [DW-1:0]    pwdata_i,
  output logic [DW-1:0]    prdata_o,
  output logic             pready_o,
  output logic             pslverr_o,
  input  logic             halt_req_i,
  input  logic             core_halted_i,
  input  logic [ROM_W-1:0] rom_base_i,
  input  logic             rom_valid_i,
  output logic             dbg_ack_o,
  output logic             no_pwrdn_o
);
  logic          wr_en, rd_en, pwr_q;
  reg_sel_e      sel;
  logic [DW-1:0] stat_word, rom_word, pwr_word;

  dbg_apb_access u_access (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .psel_i    (psel_i),
    .penable_i (penable_i),
    .pwrite_i  (pwrite_i),
    .paddr_i   (paddr_i),
    .src_dbg_i (paddr_src_i),
    .pready_o  (pready_o),
    .pslverr_o (pslverr_o),
    .wr_en_o   (wr_en),
    .rd_en_o   (rd_en),
    .sel_o     (sel)
  );

  dbg_status_ctrl u_status (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en && sel == SEL_STAT),
    .wdata_i       (pwdata_i),
    .halt_req_i    (halt_req_i),
    .core_halted_i (core_halted_i),
    .stat_o        (stat_word),
    .dbg_ack_o     (dbg_ack_o)
  );

  dbg_rom_view #(.ROM_W(ROM_W), .DW(DW)) u_rom (
    .base_i  (rom_base_i),
    .valid_i (rom_valid_i),
    .word_o  (rom_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       pwr_q <= 1'b0;
    else if (wr_en && sel == SEL_PWR)  pwr_q <= pwdata_i[0];
  end

  assign pwr_word   = {{(DW-1){1'b0}}, pwr_q};
  assign no_pwrdn_o = pwr_q;

  always_comb begin
    prdata_o = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_ROM:  prdata_o = rom_word;
        SEL_STAT: prdata_o = stat_word;
        SEL_PWR:  prdata_o = pwr_word;
        default:  prdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/dbg_apb_regs_chk.sv
module dbg_apb_regs_chk
  import dbg_apb_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          psel_i,
  input logic          penable_i,
  input logic          pwrite_i,
  input logic [AW-1:0] paddr_i,
  input logic          paddr_src_i,
  input logic [DW-1:0] prdata_o,
  input logic          pready_o,
  input logic          pslverr_o,
  input logic          core_halted_i,
  input logic          rom_valid_i,
  input logic          dbg_ack_o,
  input logic          no_pwrdn_o
);
  AST_ERR_WITH_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pslverr_o |-> (pready_o && psel_i && penable_i && pwrite_i && !paddr_src_i)); // R5

  AST_SW_STAT_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && penable_i && !$past(penable_i) && pwrite_i && !paddr_src_i
     && paddr_i == OFS_STAT) |-> !pready_o); // R5

  AST_DBG_NO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && penable_i && paddr_src_i) |-> (pready_o && !pslverr_o)); // R1

  AST_ACK_ON_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_halted_i |-> dbg_ack_o); // R7

  AST_ROM_VALID_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && penable_i && !pwrite_i && paddr_i == OFS_ROM)
      |-> (prdata_o[1:0] == {2{rom_valid_i}})); // R3

  AST_PWR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(psel_i && penable_i && pwrite_i && paddr_i == OFS_PWR) |=> $stable(no_pwrdn_o)); // R8
endmodule

bind dbg_apb_regs dbg_apb_regs_chk u_chk (.*);

// File: tb/sim_dbg_apb_regs.sv
module sim_dbg_apb_regs;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0, src = 0;
  logic [9:0]  paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic        pready, pslverr, halt_req = 0, core_halted = 0, rom_valid = 1;
  logic [19:0] rom_base = 20'hABCDE;
  logic        ack, no_pwrdn;
  int          n_chk = 0, n_err = 0, wcnt = 0;

  typedef struct { bit is_rd; logic [31:0] data; bit err; int waits; string tag; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  dbg_apb_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .paddr_src_i(src), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr), .halt_req_i(halt_req),
    .core_halted_i(core_halted), .rom_base_i(rom_base), .rom_valid_i(rom_valid),
    .dbg_ack_o(ack), .no_pwrdn_o(no_pwrdn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the expectation when a transfer completes
  always @(negedge clk) begin
    if (psel && penable) begin
      if (!pready) wcnt++;
      else begin
        exp_t e;
        if (q.size() == 0) chk("scoreboard empty", 1, 0);
        else begin
          e = q.pop_front();
          if (e.is_rd) chk({e.tag, " rdata"}, prdata, e.data);
          chk({e.tag, " pslverr"}, {31'b0, pslverr}, {31'b0, e.err});
          chk({e.tag, " waits"}, wcnt, e.waits);
        end
        wcnt = 0;
      end
    end
  end

  task automatic xfer(input bit wr, input bit s, input logic [11:0] ba, input logic [31:0] wd,
                      input logic [31:0] ed, input bit ee, input int ew, input string tag);
    exp_t e;
    e.is_rd = !wr; e.data = ed; e.err = ee; e.waits = ew; e.tag = tag;
    q.push_back(e);
    @(posedge clk); #1;
    psel = 1; penable = 0; pwrite = wr; src = s; paddr = ba[11:2]; pwdata = wd;
    @(posedge clk); #1;
    penable = 1;
    do @(negedge clk); while (!pready);
    @(posedge clk); #1;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    chk("R9 ack after reset", ack, 0);
    chk("R9 no_pwrdn after reset", no_pwrdn, 0);
    chk("R1 pready idle", pready, 0);
    xfer(0, 1, 12'h088, 0, 32'h0, 0, 0, "R9 stat reset");
    xfer(0, 1, 12'h310, 0, 32'h0, 0, 0, "R9 pwr reset");

    // ROM locator
    xfer(0, 1, 12'h000, 0, 32'hABCDE003, 0, 0, "R3 rom valid");
    xfer(1, 1, 12'h000, 32'hFFFFFFFF, 0, 0, 0, "R3 rom write");
    xfer(0, 0, 12'h000, 0, 32'hABCDE003, 0, 0, "R3 rom after write");

    // power-down word
    xfer(1, 0, 12'h310, 32'hFFFFFFFF, 0, 0, 0, "R8 pwr sw write");
    @(negedge clk); chk("R8 no_pwrdn set", no_pwrdn, 1);
    xfer(0, 1, 12'h310, 0, 32'h1, 0, 0, "R8 pwr readback");
    xfer(1, 1, 12'h310, 32'h0, 0, 0, 0, "R8 pwr clear");
    @(negedge clk); chk("R8 no_pwrdn clear", no_pwrdn, 0);

    // undecoded
    xfer(1, 1, 12'h004, 32'hFFFFFFFF, 0, 0, 0, "R2 undecoded write");
    xfer(1, 1, 12'h08C, 32'hFFFFFFFF, 0, 0, 0, "R2 undecoded write 2");
    xfer(0, 1, 12'h004, 0, 32'h0, 0, 0, "R2 undecoded read");
    xfer(0, 0, 12'hFFC, 0, 32'h0, 0, 0, "R2 top word read");
    xfer(0, 1, 12'h088, 0, 32'h0, 0, 0, "R2 stat untouched");
    @(negedge clk); chk("R2 no_pwrdn untouched", no_pwrdn, 0);
    chk("R2 ack untouched", ack, 0);

    // halt handshake
    cyc(1); halt_req = 1;
    cyc(3);
    @(negedge clk); chk("R7 ack before halt", ack, 0);
    cyc(1); core_halted = 1;
    @(negedge clk); chk("R7 ack on halt", ack, 1);
    xfer(0, 1, 12'h088, 0, 32'h10, 0, 0, "R6 entry code");
    halt_req = 0; core_halted = 0;
    @(negedge clk); chk("R7 ack after resume", ack, 0);
    xfer(0, 0, 12'h088, 0, 32'h10, 0, 0, "R6 code kept");

    // debugger and software writes to status
    xfer(1, 1, 12'h088, 32'hFFFFFFFF, 0, 0, 0, "R4 dbg write");
    xfer(0, 1, 12'h088, 0, 32'h43C, 0, 0, "R4 readback");
    @(negedge clk); chk("R7 forced ack", ack, 1);
    xfer(1, 0, 12'h088, 32'h0, 0, 1, 1, "R5 sw write");
    xfer(0, 0, 12'h088, 0, 32'h43C, 0, 0, "R5 stat unchanged");
    @(negedge clk); chk("R5 ack still forced", ack, 1);
    xfer(1, 1, 12'h088, 32'h0, 0, 0, 0, "R4 dbg clear");
    @(negedge clk); chk("R7 ack released", ack, 0);

    // halt without request leaves code alone
    cyc(1); core_halted = 1;
    cyc(2);
    xfer(0, 1, 12'h088, 0, 32'h0, 0, 0, "R6 no request");
    core_halted = 0;

    // ROM not valid
    rom_valid = 0; rom_base = '0;
    xfer(0, 1, 12'h000, 0, 32'h0, 0, 0, "R3 rom invalid");

    // reset while loaded
    xfer(1, 1, 12'h310, 32'h1, 0, 0, 0, "R8 pwr set again");
    xfer(1, 1, 12'h088, 32'h400, 0, 0, 0, "R4 force set again");
    cyc(1); rst_n = 0;
    @(negedge clk);
    chk("R9 ack in reset", ack, 0);
    chk("R9 no_pwrdn in reset", no_pwrdn, 0);
    cyc(1); rst_n = 1;
    xfer(0, 1, 12'h088, 0, 32'h0, 0, 0, "R9 stat cleared");
    cyc(2);
    chk("scoreboard drained", q.size(), 0);
    finish_run();
  end
endmodule